// File: doc/BRIEF.md
# Averaging Sweep Phase Sequencer

This block produces the control timing for a capture memory that averages repeated sweeps. The memory, the accumulator datapath and the converter interface sit elsewhere. This block drives only their aligned control inputs. Time is cut into element slots of four clock cycles. A one-cycle element strobe opens each slot. A record address steps once per slot and sweeps 0 to 999, then wraps.

Two mode flags go with the strobe. The accumulate flag tells the memory to add the incoming sample to the stored value; when it is low, a plain write is expected instead. The dump flag asks for the stored sums to be read out. The schedule runs in three phases:

- 1000 elements with accumulation;
- 8000 quiet elements with both flags low;
- 1000 elements of dump.

After the dump phase the sequencer parks in a finished state until reset. The active phase is reported as a 2-bit code.

Every output comes straight from a register, so the strobe, address, flags and phase change together on one edge. A synchronous reset restarts the whole schedule.

Top module: `avg_sweep_seq`

## Requirements
- R1: While reset is high, and up to the first clock edge after it is released, the strobe, accumulate, dump and done outputs are low, the address is 0 and the phase code is 0.
- R2: On the first edge after reset release the strobe goes high. After that it is high for exactly one cycle in every 4-cycle slot, as long as the schedule runs.
- R3: The address equals the element index modulo 1000. It changes only on a strobe cycle, holds for the rest of the slot, and goes from 999 back to 0.
- R4: During elements 0 to 999 (the first 4000 cycles after reset) the accumulate flag is high, the dump flag is low and the phase code is 0.
- R5: During elements 1000 to 8999 both flags are low and the phase code is 1.
- R6: During elements 9000 to 9999 the dump flag is high, the accumulate flag is low and the phase code is 2.
- R7: From the cycle after the last dump slot until reset, done is high, the phase code is 3, the strobe and both flags are low and the address is 0.
- R8: A reset asserted at any point, including mid-run or while done, restarts the schedule from element 0 of the accumulate phase, exactly as after the first reset.
- R9: Phase changes between the accumulate, quiet and dump phases happen only on a strobe cycle, so each slot is wholly in one phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| elem_stb_o | output | 1 | One-cycle strobe at the start of each element slot |
| rec_addr_o | output | 10 | Record address, element index modulo record length |
| add_mode_o | output | 1 | High: accumulate sample into memory; low: plain write |
| dump_req_o | output | 1 | High: read out stored sums |
| phase_o | output | 2 | 0 accumulate, 1 quiet, 2 dump, 3 finished |
| done_o | output | 1 | Schedule finished, held until reset |

## Verification
The bench compares every output on every cycle of a complete 10000-element run against a model built from element and slot arithmetic. This catches a wrong slot length, a strobe that is too long or offset, an off-by-one phase length, and an address that does not wrap at 999. A reset during the quiet phase shows whether the element, slot and address counters all restart, as opposed to only the phase. A reset from the finished state shows that done leaves only through reset and that the restart matches a cold start. Each phase entry is also checked to fall on a strobe cycle.

// File: rtl/avg_seq_pkg.sv
package avg_seq_pkg;

    typedef enum logic [1:0] {
        PH_ACC  = 2'd0,
        PH_IDLE = 2'd1,
        PH_DUMP = 2'd2,
        PH_DONE = 2'd3
    } phase_e;

    function automatic phase_e phase_after(input phase_e cur);
        case (cur)
            PH_ACC:  return PH_IDLE;
            PH_IDLE: return PH_DUMP;
            default: return PH_DONE;
        endcase
    endfunction

endpackage

// File: rtl/avg_wrap_step.sv
module avg_wrap_step #(
    parameter int LIMIT = 4,
    parameter int W     = 2
) (
    input  logic [W-1:0] cur_i,
    input  logic         en_i,
    output logic [W-1:0] nxt_o,
    output logic         wrap_o
);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    always_comb begin
        wrap_o = en_i && (cur_i == LAST);
        if (!en_i) begin
            nxt_o = cur_i;
        end else if (cur_i == LAST) begin
            nxt_o = '0;
        end else begin
            nxt_o = cur_i + 1'b1;
        end
    end
endmodule

// File: rtl/avg_phase_flags.sv
module avg_phase_flags
    import avg_seq_pkg::*;
(
    input  logic   active_i,
    input  phase_e phase_i,
    input  logic   slot_zero_i,
    output logic   stb_o,
    output logic   add_o,
    output logic   dump_o,
    output logic   done_o
);
    always_comb begin
        stb_o  = 1'b0;
        add_o  = 1'b0;
        dump_o = 1'b0;
        done_o = 1'b0;
        if (active_i) begin
            case (phase_i)
                PH_ACC: begin
                    stb_o = slot_zero_i;
                    add_o = 1'b1;
                end
                PH_IDLE: begin
                    stb_o = slot_zero_i;
                end
                PH_DUMP: begin
                    stb_o  = slot_zero_i;
                    dump_o = 1'b1;
                end
                default: begin
                    done_o = 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/avg_sweep_seq.sv
module avg_sweep_seq
    import avg_seq_pkg::*;
#(
    parameter int SLOT_CYCLES = 4,
    parameter int REC_LEN     = 1000,
    parameter int ACC_ELEMS   = 1000,
    parameter int IDLE_ELEMS  = 8000,
    parameter int DUMP_ELEMS  = 1000,
    localparam int AW = (REC_LEN > 1) ? $clog2(REC_LEN) : 1
) (
    input  logic          clk,
    input  logic          rst,
    output logic          elem_stb_o,
    output logic [AW-1:0] rec_addr_o,
    output logic          add_mode_o,
    output logic          dump_req_o,
    output logic [1:0]    phase_o,
    output logic          done_o
);
    localparam int SW    = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
    localparam int MAX_A = (ACC_ELEMS > IDLE_ELEMS) ? ACC_ELEMS : IDLE_ELEMS;
    localparam int MAXL  = (MAX_A > DUMP_ELEMS) ? MAX_A : DUMP_ELEMS;
    localparam int EW    = $clog2(MAXL + 1);

    localparam logic [EW-1:0] ACC_LAST  = EW'(ACC_ELEMS - 1);
    localparam logic [EW-1:0] IDLE_LAST = EW'(IDLE_ELEMS - 1);
    localparam logic [EW-1:0] DUMP_LAST = EW'(DUMP_ELEMS - 1);

    typedef struct packed {
        logic          started;
        phase_e        phase;
        logic [SW-1:0] slot;
        logic [EW-1:0] elem;
        logic [AW-1:0] addr;
    } pos_t;

    typedef struct packed {
        logic stb;
        logic add;
        logic dump;
        logic done;
    } flag_t;

    pos_t  pos_d, pos_q;
    flag_t flg_d, flg_q;

    logic          run;
    logic [SW-1:0] slot_nxt;
    logic          slot_wrap;
    logic [AW-1:0] addr_nxt;
    logic          addr_wrap;
    logic [EW-1:0] phase_last;

    assign run = pos_q.started && (pos_q.phase != PH_DONE);

    avg_wrap_step #(.LIMIT(SLOT_CYCLES), .W(SW)) u_slot_step (
        .cur_i  (pos_q.slot),
        .en_i   (run),
        .nxt_o  (slot_nxt),
        .wrap_o (slot_wrap)
    );

    avg_wrap_step #(.LIMIT(REC_LEN), .W(AW)) u_addr_step (
        .cur_i  (pos_q.addr),
        .en_i   (slot_wrap),
        .nxt_o  (addr_nxt),
        .wrap_o (addr_wrap)
    );

    always_comb begin
        case (pos_q.phase)
            PH_ACC:  phase_last = ACC_LAST;
            PH_IDLE: phase_last = IDLE_LAST;
            default: phase_last = DUMP_LAST;
        endcase
    end

    always_comb begin
        pos_d = pos_q;
        if (!pos_q.started) begin
            pos_d.started = 1'b1;
            pos_d.phase   = PH_ACC;
            pos_d.slot    = '0;
            pos_d.elem    = '0;
            pos_d.addr    = '0;
        end else if (run) begin
            pos_d.slot = slot_nxt;
            if (slot_wrap) begin
                pos_d.addr = addr_nxt;
                if (pos_q.elem == phase_last) begin
                    pos_d.elem  = '0;
                    pos_d.phase = phase_after(pos_q.phase);
                end else begin
                    pos_d.elem = pos_q.elem + 1'b1;
                end
            end
        end
    end

    avg_phase_flags u_flags (
        .active_i    (pos_d.started),
        .phase_i     (pos_d.phase),
        .slot_zero_i (pos_d.slot == '0),
        .stb_o       (flg_d.stb),
        .add_o       (flg_d.add),
        .dump_o      (flg_d.dump),
        .done_o      (flg_d.done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q.started <= 1'b0;
            pos_q.phase   <= PH_ACC;
            pos_q.slot    <= '0;
            pos_q.elem    <= '0;
            pos_q.addr    <= '0;
            flg_q         <= '0;
        end else begin
            pos_q <= pos_d;
            flg_q <= flg_d;
        end
    end

    assign elem_stb_o = flg_q.stb;
    assign rec_addr_o = pos_q.addr;
    assign add_mode_o = flg_q.add;
    assign dump_req_o = flg_q.dump;
    assign phase_o    = pos_q.phase;
    assign done_o     = flg_q.done;

    // R2
    strobe_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (elem_stb_o && SLOT_CYCLES > 1) |=> !elem_stb_o);

    // R3
    addr_on_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(rec_addr_o) |-> (elem_stb_o || done_o));

    // R6
    mode_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(add_mode_o && dump_req_o));

    // R7
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (done_o && !elem_stb_o && !add_mode_o && !dump_req_o));

    // R9
    phase_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        (!$stable(phase_o) && !done_o) |-> elem_stb_o);
endmodule

// File: tb/avg_sweep_seq_tb.sv
module avg_sweep_seq_tb;
    localparam int TOTAL_CYC = 4 * 10000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       stb;
    logic [9:0] addr;
    logic       add_m;
    logic       dmp;
    logic [1:0] ph;
    logic       done;

    int checks = 0;
    int errors = 0;
    int prev_ph;

    always #2.5 clk = ~clk;

    avg_sweep_seq u_dut (
        .clk        (clk),
        .rst        (rst),
        .elem_stb_o (stb),
        .rec_addr_o (addr),
        .add_mode_o (add_m),
        .dump_req_o (dmp),
        .phase_o    (ph),
        .done_o     (done)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic chk_cycle(input int c);
        int g = c / 4;
        int s = c % 4;
        string pt;
        if (g < 10000) begin
            pt = (g < 1000) ? "R4" : (g < 9000) ? "R5" : "R6";
            chk("R2", "strobe", int'(stb), int'(s == 0));
            chk("R3", "addr", int'(addr), g % 1000);
            chk(pt, "add", int'(add_m), int'(g < 1000));
            chk(pt, "dump", int'(dmp), int'(g >= 9000));
            chk(pt, "phase", int'(ph), (g < 1000) ? 0 : (g < 9000) ? 1 : 2);
            chk(pt, "done", int'(done), 0);
        end else begin
            chk("R7", "strobe", int'(stb), 0);
            chk("R7", "addr", int'(addr), 0);
            chk("R7", "add", int'(add_m), 0);
            chk("R7", "dump", int'(dmp), 0);
            chk("R7", "phase", int'(ph), 3);
            chk("R7", "done", int'(done), 1);
        end
        if (int'(ph) != prev_ph && ph != 2'd3)
            chk("R9", "strobe at phase change", int'(stb), 1);
        prev_ph = int'(ph);
    endtask

    task automatic chk_idle_state(input string tag);
        chk(tag, "strobe", int'(stb), 0);
        chk(tag, "addr", int'(addr), 0);
        chk(tag, "add", int'(add_m), 0);
        chk(tag, "dump", int'(dmp), 0);
        chk(tag, "phase", int'(ph), 0);
        chk(tag, "done", int'(done), 0);
    endtask

    task automatic release_reset();
        @(negedge clk);
        rst = 1'b0;
        chk_idle_state("R1");
        prev_ph = 0;
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk_idle_state(tag);
    endtask

    task automatic test_reset_state();
        repeat (3) @(posedge clk);
        #1;
        chk_idle_state("R1");
    endtask

    task automatic test_full_schedule();
        release_reset();
        for (int c = 0; c < TOTAL_CYC + 40; c++) begin
            @(posedge clk);
            #1;
            chk_cycle(c);
        end
    endtask

    task automatic test_reset_from_done();
        do_reset("R8");
        release_reset();
        for (int c = 0; c < 4100; c++) begin
            @(posedge clk);
            #1;
            chk_cycle(c);
        end
    endtask

    task automatic test_midrun_reset();
        do_reset("R8");
        release_reset();
        for (int c = 0; c < 20; c++) begin
            @(posedge clk);
            #1;
            chk_cycle(c);
        end
    endtask

    initial begin
        test_reset_state();
        test_full_schedule();
        test_reset_from_done();
        test_midrun_reset();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule